// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Line Controller

This block tracks coherence state for a private cache that writes through and does not allocate on a write miss. Each of `NUM_LINES` lines, selected directly by its line index, holds one state bit: Valid or Invalid. The core presents load, store and evict requests with a line index. When a request needs the shared bus, the block raises a bus request with a read or write command and waits for the arbiter's grant. Transactions that other caches place on the bus are snooped so that stale local copies are dropped.

Line state changes only on a granted cycle, on an evict, or on a snooped write. Loads that hit and evicts finish at once. Loads that miss, and all stores, wait in a request state until the grant arrives. The core sees the end of every request as a one-cycle response pulse with a hit flag. Tags, data storage and arbitration belong to neighbouring logic.

Request states: `ST_IDLE` accepts a new core request. `ST_WAIT_GNT` holds a bus request until the grant arrives. Transitions: IDLE→WAIT_GNT on a load to an Invalid line or on any store. WAIT_GNT→IDLE on `bus_gnt`. Every other case stays in the current state.

Top module: `vi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_busy` are 0 and no response is signalled.
- R2: A load (`cpu_op`=1) to an Invalid line raises `bus_req` with `bus_cmd`=1 (read) and the line index from the next cycle on. On the granted edge the line becomes Valid and a response with hit=0 follows in the next cycle.
- R3: A load to a Valid line gives a response with hit=1 in the next cycle and raises no bus request.
- R4: A store (`cpu_op`=2) to an Invalid line raises `bus_req` with `bus_cmd`=2 (write). On grant it responds with hit=0 and the line stays Invalid.
- R5: A store to a Valid line raises a write bus request. On grant it responds with hit=1 and the line stays Valid.
- R6: An evict (`cpu_op`=3) makes the line Invalid with no bus request and responds with hit=0 in the next cycle.
- R7: A snooped write (`snp_valid`=1, `snp_cmd`=2) makes the indexed line Invalid. It wins over a same-cycle load grant to the same line.
- R8: A snooped read (`snp_cmd`=1) leaves every line unchanged.
- R9: While a request waits, `bus_req`, `bus_cmd` and `bus_idx` stay constant and new core requests are ignored. A grant outside a wait has no effect, and line state changes only on the granted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 2 | Core request: 0 none, 1 load, 2 store, 3 evict |
| cpu_idx | input | IDX_W | Line index of the core request |
| cpu_busy | output | 1 | A request is waiting for the bus; new requests are ignored |
| resp_valid | output | 1 | One-cycle pulse when a request completes |
| resp_hit | output | 1 | Line was Valid when the request completed |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 2 | Bus command: 0 idle, 1 read, 2 write |
| bus_idx | output | IDX_W | Line index of the bus request |
| bus_gnt | input | 1 | Grant from the arbiter |
| snp_valid | input | 1 | A snooped transaction from another cache is present |
| snp_cmd | input | 2 | Snooped command: 1 read, 2 write |
| snp_idx | input | IDX_W | Line index of the snooped transaction |

## Verification
Directed sequences cover the following cases:
- a miss, then a hit on the same line, which separates the read-fill path from the hit path;
- stores to a Valid line and to an Invalid line, whose hit flags and later probe loads show write-through with no allocation;
- an evict;
- a snooped read against a snooped write on a held line;
- a grant that coincides with a snooped write to the same line.

Seeded random mixes of operations, grant delays, stray grants and snoop traffic then compare every output each cycle against a reference model. This exposes ordering mistakes between fills, evicts and snoop clears, and any request that is not held during the wait.

// File: rtl/vi_snoop_pkg.sv
package vi_snoop_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_EVICT = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_IDLE  = 2'd0,
        BC_READ  = 2'd1,
        BC_WRITE = 2'd2,
        BC_RSVD  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_GNT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/vi_snoop_filter.sv
module vi_snoop_filter #(
    parameter int IDX_W = 4
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             kill_en,
    output logic [IDX_W-1:0] kill_idx
);
    import vi_snoop_pkg::*;

    // Only a foreign write makes the local copy stale; reads leave it alone.
    always_comb begin
        kill_en  = snp_valid && (bus_cmd_e'(snp_cmd) == BC_WRITE);
        kill_idx = snp_idx;
    end
endmodule

// File: rtl/vi_line_array.sv
module vi_line_array #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 evict_en,
    input  logic [IDX_W-1:0]     evict_idx,
    input  logic                 kill_en,
    input  logic [IDX_W-1:0]     kill_idx,
    output logic [NUM_LINES-1:0] valid_vec
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic fill_hit;
        logic drop_hit;

        always_comb begin
            fill_hit = fill_en && (fill_idx == IDX_W'(g));
            drop_hit = (evict_en && (evict_idx == IDX_W'(g)))
                    || (kill_en && (kill_idx == IDX_W'(g)));
        end

        // Clearing wins over filling on the same edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
            end else if (drop_hit) begin
                valid_vec[g] <= 1'b0;
            end else if (fill_hit) begin
                valid_vec[g] <= 1'b1;
            end
        end
    end

    a_r7_snoop_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |=> !valid_vec[$past(kill_idx)]);

    a_r8_quiet_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !evict_en && !kill_en) |=> $stable(valid_vec));

    a_r2_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(kill_en && kill_idx == fill_idx)) |=> valid_vec[$past(fill_idx)]);
endmodule

// File: rtl/vi_req_fsm.sv
module vi_req_fsm #(
    parameter int IDX_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  vi_snoop_pkg::cpu_op_e         cpu_op,
    input  logic [IDX_W-1:0]              cpu_idx,
    input  logic                          cpu_line_valid,
    input  logic                          pend_line_valid,
    input  logic                          bus_gnt,
    output logic                          bus_req,
    output vi_snoop_pkg::bus_cmd_e        bus_cmd,
    output logic [IDX_W-1:0]              bus_idx,
    output logic                          busy,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic                          fill_en,
    output logic [IDX_W-1:0]              fill_idx,
    output logic                          evict_en,
    output logic [IDX_W-1:0]              evict_idx
);
    import vi_snoop_pkg::*;

    ctl_state_e       state_q, state_d;
    cpu_op_e          op_q;
    logic [IDX_W-1:0] idx_q;
    logic             need_bus;
    logic             granted;
    logic             resp_valid_d, resp_hit_d;

    always_comb begin
        need_bus = (cpu_op == OP_STORE) || ((cpu_op == OP_LOAD) && !cpu_line_valid);
        granted  = (state_q == ST_WAIT_GNT) && bus_gnt;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (need_bus) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt)  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pending request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            idx_q <= '0;
        end else if ((state_q == ST_IDLE) && need_bus) begin
            op_q  <= cpu_op;
            idx_q <= cpu_idx;
        end
    end

    // Response and output logic.
    always_comb begin
        resp_valid_d = 1'b0;
        resp_hit_d   = 1'b0;
        bus_req      = 1'b0;
        bus_cmd      = BC_IDLE;
        busy         = 1'b0;
        fill_en      = 1'b0;
        evict_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if ((cpu_op == OP_LOAD) && cpu_line_valid) begin
                    resp_valid_d = 1'b1;
                    resp_hit_d   = 1'b1;
                end else if (cpu_op == OP_EVICT) begin
                    resp_valid_d = 1'b1;
                    evict_en     = 1'b1;
                end
            end
            ST_WAIT_GNT: begin
                bus_req = 1'b1;
                busy    = 1'b1;
                bus_cmd = (op_q == OP_STORE) ? BC_WRITE : BC_READ;
                if (granted) begin
                    resp_valid_d = 1'b1;
                    resp_hit_d   = (op_q == OP_STORE) && pend_line_valid;
                    fill_en      = (op_q == OP_LOAD);
                end
            end
            default: ;
        endcase
        bus_idx   = idx_q;
        fill_idx  = idx_q;
        evict_idx = cpu_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
        end else begin
            resp_valid <= resp_valid_d;
            resp_hit   <= resp_hit_d;
        end
    end

    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_idx)));

    a_r2_grant_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> (resp_valid && !bus_req));

    a_r3_resp_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !bus_req);

    a_r9_req_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd == BC_READ || bus_cmd == BC_WRITE));
endmodule

// File: rtl/vi_snoop_ctrl.sv
module vi_snoop_ctrl #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_busy,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx
);
    import vi_snoop_pkg::*;

    logic [NUM_LINES-1:0] valid_vec;
    logic                 fill_en, evict_en, kill_en;
    logic [IDX_W-1:0]     fill_idx, evict_idx, kill_idx;
    logic                 cpu_line_valid, pend_line_valid;
    bus_cmd_e             bus_cmd_w;

    always_comb begin
        cpu_line_valid  = valid_vec[cpu_idx];
        pend_line_valid = valid_vec[bus_idx];
        bus_cmd         = bus_cmd_w;
    end

    vi_snoop_filter #(.IDX_W(IDX_W)) u_filter (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_idx   (snp_idx),
        .kill_en   (kill_en),
        .kill_idx  (kill_idx)
    );

    vi_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .evict_en  (evict_en),
        .evict_idx (evict_idx),
        .kill_en   (kill_en),
        .kill_idx  (kill_idx),
        .valid_vec (valid_vec)
    );

    vi_req_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_op          (cpu_op_e'(cpu_op)),
        .cpu_idx         (cpu_idx),
        .cpu_line_valid  (cpu_line_valid),
        .pend_line_valid (pend_line_valid),
        .bus_gnt         (bus_gnt),
        .bus_req         (bus_req),
        .bus_cmd         (bus_cmd_w),
        .bus_idx         (bus_idx),
        .busy            (cpu_busy),
        .resp_valid      (resp_valid),
        .resp_hit        (resp_hit),
        .fill_en         (fill_en),
        .fill_idx        (fill_idx),
        .evict_en        (evict_en),
        .evict_idx       (evict_idx)
    );

    a_r6_evict_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_busy && cpu_op == 2'd3) |=> !bus_req);
endmodule

// File: tb/vi_snoop_ctrl_test.sv
module vi_snoop_ctrl_test;
    localparam int NUM_LINES = 16;
    localparam int IDX_W     = $clog2(NUM_LINES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cpu_op = 2'd0;
    logic [IDX_W-1:0] cpu_idx = '0;
    logic             cpu_busy, resp_valid, resp_hit, bus_req;
    logic [1:0]       bus_cmd;
    logic [IDX_W-1:0] bus_idx;
    logic             bus_gnt = 1'b0;
    logic             snp_valid = 1'b0;
    logic [1:0]       snp_cmd = 2'd0;
    logic [IDX_W-1:0] snp_idx = '0;

    always #10 clk = ~clk;

    vi_snoop_ctrl #(.NUM_LINES(NUM_LINES)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_busy(cpu_busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx), .bus_gnt(bus_gnt),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference model
    bit               m_valid [NUM_LINES];
    bit               m_wait;
    logic [1:0]       m_op;
    logic [IDX_W-1:0] m_idx;
    bit               m_resp, m_hit;
    string            m_tag = "R1";

    function automatic logic [1:0] exp_cmd();
        if (!m_wait) return 2'd0;
        return (m_op == 2'd2) ? 2'd2 : 2'd1;
    endfunction

    function automatic string req_tag();
        if (!m_wait) return "R3";
        return (m_op == 2'd2) ? "R4" : "R2";
    endfunction

    task automatic check(string what, string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("bus_req", req_tag(), bus_req, m_wait);
        check("cpu_busy", "R9", cpu_busy, m_wait);
        check("bus_cmd", req_tag(), bus_cmd, exp_cmd());
        if (m_wait) check("bus_idx", "R9", bus_idx, m_idx);
        check("resp_valid", m_tag, resp_valid, m_resp);
        if (m_resp) check("resp_hit", m_tag, resp_hit, m_hit);
    endtask

    task automatic model_step();
        bit old_v [NUM_LINES];
        old_v = m_valid;
        m_resp = 0;
        m_hit  = 0;
        if (m_wait) begin
            if (bus_gnt) begin
                m_resp = 1;
                m_hit  = (m_op == 2'd2) && old_v[m_idx];
                m_tag  = (m_op == 2'd2) ? (old_v[m_idx] ? "R5" : "R4") : "R2";
                if (m_op == 2'd1) m_valid[m_idx] = 1;
                m_wait = 0;
            end
        end else begin
            unique case (cpu_op)
                2'd1: if (old_v[cpu_idx]) begin
                          m_resp = 1; m_hit = 1; m_tag = "R3";
                      end else begin
                          m_wait = 1; m_op = cpu_op; m_idx = cpu_idx;
                      end
                2'd2: begin m_wait = 1; m_op = cpu_op; m_idx = cpu_idx; end
                2'd3: begin m_resp = 1; m_tag = "R6"; m_valid[cpu_idx] = 0; end
                default: ;
            endcase
        end
        // R7: snooped write clears after any fill
        if (snp_valid && snp_cmd == 2'd2) m_valid[snp_idx] = 0;
    endtask

    // One cycle: drive at negedge, advance model at posedge, compare at next negedge.
    task automatic cycle(input logic [1:0] op, input int idx, input bit gnt,
                         input bit sv, input logic [1:0] sc, input int si);
        cpu_op    = op;
        cpu_idx   = IDX_W'(idx);
        bus_gnt   = gnt;
        snp_valid = sv;
        snp_cmd   = sc;
        snp_idx   = IDX_W'(si);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(2'd0, 0, 0, 0, 2'd0, 0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        foreach (m_valid[i]) m_valid[i] = 0;
        m_wait = 0; m_op = 0; m_idx = 0; m_resp = 0; m_hit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all(); // R1 reset state
        // R1: every line Invalid after reset: loads to lines 0 and 9 must miss
        cycle(2'd1, 0, 0, 0, 0, 0);
        check("miss after reset", "R1", bus_req, 1);
        cycle(2'd0, 0, 1, 0, 0, 0);
        cycle(2'd1, 9, 0, 0, 0, 0);
        check("miss after reset", "R1", bus_req, 1);
        cycle(2'd0, 0, 1, 0, 0, 0);
        // R2 load miss with delayed grant, R9 ignored ops while waiting
        cycle(2'd1, 3, 0, 0, 0, 0);
        cycle(2'd3, 3, 0, 0, 0, 0);
        cycle(2'd2, 7, 0, 0, 0, 0);
        cycle(2'd0, 0, 1, 0, 0, 0);
        // R3 hit
        cycle(2'd1, 3, 0, 0, 0, 0);
        // R5 store to Valid
        cycle(2'd2, 3, 0, 0, 0, 0);
        cycle(2'd0, 0, 1, 0, 0, 0);
        cycle(2'd1, 3, 0, 0, 0, 0);
        // R4 store to Invalid, then probe stays a miss
        cycle(2'd2, 5, 0, 0, 0, 0);
        cycle(2'd0, 0, 1, 0, 0, 0);
        cycle(2'd1, 5, 0, 0, 0, 0);
        check("no allocate probe", "R4", bus_req, 1);
        cycle(2'd0, 0, 1, 0, 0, 0);
        // R9 stray grant while idle
        cycle(2'd0, 0, 1, 0, 0, 0);
        // R8 snoop read keeps line 3, R7 snoop write drops it
        cycle(2'd0, 0, 0, 1, 2'd1, 3);
        cycle(2'd1, 3, 0, 0, 0, 0);
        check("snoop read keeps", "R8", resp_hit, 1);
        cycle(2'd0, 0, 0, 1, 2'd2, 3);
        cycle(2'd1, 3, 0, 0, 0, 0);
        check("snoop write drops", "R7", bus_req, 1);
        // R7 grant and snoop write to same line on same edge
        cycle(2'd0, 0, 1, 1, 2'd2, 3);
        cycle(2'd1, 3, 0, 0, 0, 0);
        check("snoop beats fill", "R7", bus_req, 1);
        cycle(2'd0, 0, 1, 0, 0, 0);
        // R6 evict
        cycle(2'd3, 3, 0, 0, 0, 0);
        cycle(2'd1, 3, 0, 0, 0, 0);
        check("evict drops", "R6", bus_req, 1);
        cycle(2'd0, 0, 1, 0, 0, 0);
        idle(2);
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] op;
            bit g, sv;
            op = 2'($urandom_range(0, 3));
            g  = ($urandom_range(0, 99) < 35);
            sv = ($urandom_range(0, 99) < 25);
            cycle(op, $urandom_range(0, NUM_LINES - 1), g, sv,
                  2'($urandom_range(1, 2)), $urandom_range(0, NUM_LINES - 1));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule